// File: doc/BRIEF.md
# Link Packet Formatter

This block sits at the transmit end of a point-to-point cluster link. A host pushes 32-bit words into it. Each write starts with a word that holds the destination address and carries header fields alongside: destination node, command and sender node. The write ends with a word that carries the end marker. The formatter turns every write into one or more framed packets on a 16-bit channel. A framing signal stays high for the whole length of each packet, and every packet ends with two cycles of CRC.

Besides data, the formatter sends short control packets. These report the port status, the configuration, the hub status and a global status word. A control packet is sent at once, at the next packet boundary, when the port status input changes. When nothing changes, one is sent at a fixed interval. Control packets never split a data packet, but they go ahead of any data that is waiting. A data packet starts only when all of its words are already held in the internal queue. Once started, it goes out at one link cycle per half word, with no gaps.

Top module: `link_pkt_fmt`

## Requirements
- R1: The first cycle of every packet is a header laid out as {type[15:12], destination[11:8], command[7:4], sender[3:0]}. The type code is 4'h1 for data packets and 4'hC for control packets.
- R2: After the header, a data packet carries the 32-bit address and then the data words in queue order. Each 32-bit word takes two cycles, upper half first.
- R3: The last two cycles of every packet hold a CRC-32 (polynomial 0x04C11DB7, seed 0xFFFFFFFF, no final inversion). It is computed MSB first over every 16-bit cycle from the header up to the last payload cycle and is sent upper half first.
- R4: `link_frame` is high for exactly the cycles of a packet, including both CRC cycles, and is low for at least one cycle between packets. After reset `link_frame` is low and `wr_ready` is high.
- R5: A data packet carries at most MAX_PAY_BYTES/4 - 1 data words (63 by default), so the address and data together are at most 256 bytes. A longer write is cut into several packets. Each of them repeats the header and carries an address advanced by 4 times that word count for each packet before it.
- R6: A write that consists of the address word alone gives a 5-cycle packet: header, two address cycles and two CRC cycles.
- R7: Separate writes always give separate packets, even when they are queued back to back.
- R8: No cycle of a data packet is sent before the word that closes it has been accepted. That word is either the write's last word or the word that fills the packet.
- R9: A control packet is 5 cycles long: {4'hC, ctl_dst, ctl_cfg}, {ctl_port_stat, ctl_hub_stat}, ctl_glob_stat, then the CRC. Its values are taken in the idle cycle before it starts.
- R10: A change on `ctl_port_stat` causes a control packet. When the link is idle, it starts two clock edges after the change is sampled. Otherwise it starts at the end of the data packet in flight, ahead of any queued data, and that data packet is never interrupted.
- R11: When the port status does not change and the link is otherwise idle, control packets start exactly CTL_PERIOD cycles apart.
- R12: `wr_ready` is low whenever the queue is full. Words offered while it is low are not taken, and no accepted word is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Host offers a word |
| wr_ready | output | 1 | Queue can take a word |
| wr_word | input | 32 | Address word (on start) or data word |
| wr_sop | input | 1 | Word is the first (address) word of a write |
| wr_eop | input | 1 | Word is the last word of a write |
| wr_dst | input | 4 | Destination node, taken with the first word |
| wr_cmd | input | 4 | Command, taken with the first word |
| wr_src | input | 4 | Sender node, taken with the first word |
| ctl_dst | input | 4 | Destination field of control packets |
| ctl_cfg | input | 8 | Configuration field of control packets |
| ctl_port_stat | input | 8 | Port status; a change requests a control packet |
| ctl_hub_stat | input | 8 | Hub status field |
| ctl_glob_stat | input | 16 | Global status field |
| link_data | output | 16 | Link cycle value |
| link_frame | output | 1 | High during every cycle of a packet |

## Verification
The hardest case to reach is a status change that arrives while a long data packet is on the wire and a second write is already fully queued behind it. At that moment the control request must win the next boundary but must not cut into the packet in flight. The bench queues a 40-word write and a 1-word write back to back, then waits until the first packet is part way out before it changes the port status. Filling the queue is the other hard case. The bench uses a queue of 64 entries and pushes a 101-word write at one word per cycle, which drives `wr_ready` low while the packet split is under way.

// File: rtl/lpf_pkg.sv
// Shared types, codes and the CRC step used by the link packet formatter.
package lpf_pkg;

    localparam logic [3:0]  TYPE_DATA = 4'h1;
    localparam logic [3:0]  TYPE_CTRL = 4'hC;
    localparam logic [31:0] CRC_POLY  = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED  = 32'hFFFF_FFFF;

    typedef struct packed {
        logic [3:0] dst;
        logic [3:0] cmd;
        logic [3:0] src;
    } hdr_t;

    // One queue entry: a host word with its markers and header fields
    typedef struct packed {
        logic        sop_f;   // first word of a write (address word)
        logic        end_f;   // last word of a packet segment
        hdr_t        hdr;
        logic [31:0] word;
    } qent_t;

    typedef enum logic [3:0] {
        S_IDLE, S_HDR, S_AHI, S_ALO, S_DHI, S_DLO,
        S_C0, S_C1, S_C2, S_EHI, S_ELO
    } seq_t;

    // Advance a CRC-32 over one 16-bit link cycle, MSB first
    function automatic logic [31:0] crc_step16(input logic [31:0] c, input logic [15:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 15; i >= 0; i--) begin
            if (r[31] ^ d[i]) r = (r << 1) ^ CRC_POLY;
            else              r = r << 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/lpf_queue.sv
// Word queue with packet segmentation on the write side.
// Marks the word that closes each packet (end of write, or the word that
// fills a packet) and counts complete packets held. Assumes DEPTH is at
// least SEG_WORDS + 1 so that a full-size packet fits.
module lpf_queue
    import lpf_pkg::*;
#(
    parameter int DEPTH     = 128,
    parameter int SEG_WORDS = 63,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1),
    localparam int SW = $clog2(SEG_WORDS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [31:0]   in_word,
    input  logic          in_sop,
    input  logic          in_eop,
    input  hdr_t          in_hdr,
    output qent_t         head,
    input  logic          pop,
    input  logic          pkt_take,
    output logic [CW-1:0] pkts,
    output logic [CW-1:0] used
);

    qent_t          mem [DEPTH];
    logic [AW-1:0]  wp, rp;
    logic [SW-1:0]  seg_cnt;
    logic           push, seg_end;

    assign in_ready = (used != CW'(DEPTH));
    assign push     = in_valid && in_ready;
    assign head     = mem[rp];

    // Decide whether the incoming word closes a packet
    always_comb begin
        if (in_sop) seg_end = in_eop;
        else        seg_end = in_eop || (seg_cnt == SW'(SEG_WORDS - 1));
    end

    // Store words; storage itself needs no reset
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= '{sop_f: in_sop, end_f: seg_end, hdr: in_hdr, word: in_word};
    end

    // Pointers, fill level and complete-packet count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp   <= '0;
            rp   <= '0;
            used <= '0;
            pkts <= '0;
        end else begin
            if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            used <= used + CW'(push) - CW'(pop);
            pkts <= pkts + CW'(push && seg_end) - CW'(pkt_take);
        end
    end

    // Count data words of the current segment (the address word is not counted)
    always_ff @(posedge clk) begin
        if (!rst_n)                 seg_cnt <= '0;
        else if (push && in_sop)    seg_cnt <= '0;
        else if (push && seg_end)   seg_cnt <= '0;
        else if (push)              seg_cnt <= seg_cnt + 1'b1;
    end

endmodule

// File: rtl/lpf_ctl_sched.sv
// Control packet scheduler. Raises a pending request when the port status
// changes or when the interval timer expires; the request drops when the
// sequencer starts a control packet. Assumes PERIOD is at least 8.
module lpf_ctl_sched #(
    parameter int PERIOD = 100000,
    localparam int TW = $clog2(PERIOD + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] port_stat,
    input  logic       start,
    output logic       pend
);

    logic [7:0]    seen;
    logic [TW-1:0] tick;
    logic          changed, expire;

    assign changed = (port_stat != seen);
    assign expire  = (tick == TW'(PERIOD - 1));

    // Remember last port status to detect changes
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= '0;
        else        seen <= port_stat;
    end

    // Interval timer, restarted by each control packet
    always_ff @(posedge clk) begin
        if (!rst_n)      tick <= '0;
        else if (start)  tick <= TW'(1);
        else if (expire) tick <= '0;
        else             tick <= tick + 1'b1;
    end

    // Pending flag; a new cause wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)                 pend <= 1'b0;
        else if (changed || expire) pend <= 1'b1;
        else if (start)             pend <= 1'b0;
    end

endmodule

// File: rtl/lpf_seq.sv
// Link sequencer. From idle it starts a control packet if one is pending,
// else a data packet if a complete one is queued; it walks header, address,
// data halves and CRC cycles, and returns to idle for one cycle between
// packets. Assumes the queue head is valid whenever pkts_nz was seen.
module lpf_seq
    import lpf_pkg::*;
#(
    parameter int SEG_WORDS = 63
) (
    input  logic        clk,
    input  logic        rst_n,
    input  qent_t       head,
    input  logic        pkts_nz,
    input  logic        ctl_pend,
    input  logic [3:0]  ctl_dst,
    input  logic [7:0]  ctl_cfg,
    input  logic [7:0]  ctl_port_stat,
    input  logic [7:0]  ctl_hub_stat,
    input  logic [15:0] ctl_glob_stat,
    output logic        pop,
    output logic        pkt_take,
    output logic        ctl_start,
    output logic        idle,
    output logic [15:0] link_data,
    output logic        link_frame
);

    localparam logic [31:0] ADDR_STEP = 32'(4 * SEG_WORDS);

    seq_t        st;
    hdr_t        hdr_r;
    logic [31:0] addr_r, addr_nxt, crc_r;
    logic [15:0] ctl0, ctl1, ctl2;
    logic        addr_only;
    logic        in_body;

    assign idle       = (st == S_IDLE);
    assign link_frame = (st != S_IDLE);
    assign ctl_start  = idle && ctl_pend;
    assign pkt_take   = idle && !ctl_pend && pkts_nz;
    assign pop        = (pkt_take && head.sop_f) || (st == S_DLO);
    assign in_body    = link_frame && (st != S_EHI) && (st != S_ELO);

    // Value placed on the link in the current cycle
    always_comb begin
        case (st)
            S_HDR:   link_data = {TYPE_DATA, hdr_r};
            S_AHI:   link_data = addr_r[31:16];
            S_ALO:   link_data = addr_r[15:0];
            S_DHI:   link_data = head.word[31:16];
            S_DLO:   link_data = head.word[15:0];
            S_C0:    link_data = ctl0;
            S_C1:    link_data = ctl1;
            S_C2:    link_data = ctl2;
            S_EHI:   link_data = crc_r[31:16];
            S_ELO:   link_data = crc_r[15:0];
            default: link_data = 16'h0000;
        endcase
    end

    // State walk through packet cycles
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else begin
            case (st)
                S_IDLE:  if (ctl_start) st <= S_C0;
                         else if (pkt_take) st <= S_HDR;
                S_HDR:   st <= S_AHI;
                S_AHI:   st <= S_ALO;
                S_ALO:   st <= addr_only ? S_EHI : S_DHI;
                S_DHI:   st <= S_DLO;
                S_DLO:   st <= head.end_f ? S_EHI : S_DHI;
                S_C0:    st <= S_C1;
                S_C1:    st <= S_C2;
                S_C2:    st <= S_EHI;
                S_EHI:   st <= S_ELO;
                default: st <= S_IDLE;
            endcase
        end
    end

    // Capture header, address and control snapshot at packet start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_r     <= '0;
            addr_r    <= '0;
            addr_nxt  <= '0;
            addr_only <= 1'b0;
            ctl0      <= '0;
            ctl1      <= '0;
            ctl2      <= '0;
        end else if (ctl_start) begin
            ctl0 <= {TYPE_CTRL, ctl_dst, ctl_cfg};
            ctl1 <= {ctl_port_stat, ctl_hub_stat};
            ctl2 <= ctl_glob_stat;
        end else if (pkt_take) begin
            if (head.sop_f) begin
                hdr_r     <= head.hdr;
                addr_r    <= head.word;
                addr_nxt  <= head.word + ADDR_STEP;
                addr_only <= head.end_f;
            end else begin
                addr_r    <= addr_nxt;
                addr_nxt  <= addr_nxt + ADDR_STEP;
                addr_only <= 1'b0;
            end
        end
    end

    // Running CRC over header and payload cycles
    always_ff @(posedge clk) begin
        if (!rst_n || idle) crc_r <= CRC_SEED;
        else if (in_body)   crc_r <= crc_step16(crc_r, link_data);
    end

endmodule

// File: rtl/link_pkt_fmt.sv
// Link packet formatter top. Connects the word queue, the control scheduler
// and the link sequencer. Assumes FIFO_DEPTH >= MAX_PAY_BYTES/4 and
// MAX_PAY_BYTES a multiple of 4 of at least 8.
module link_pkt_fmt
    import lpf_pkg::*;
#(
    parameter int MAX_PAY_BYTES = 256,
    parameter int FIFO_DEPTH    = 128,
    parameter int CTL_PERIOD    = 100000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_valid,
    output logic        wr_ready,
    input  logic [31:0] wr_word,
    input  logic        wr_sop,
    input  logic        wr_eop,
    input  logic [3:0]  wr_dst,
    input  logic [3:0]  wr_cmd,
    input  logic [3:0]  wr_src,
    input  logic [3:0]  ctl_dst,
    input  logic [7:0]  ctl_cfg,
    input  logic [7:0]  ctl_port_stat,
    input  logic [7:0]  ctl_hub_stat,
    input  logic [15:0] ctl_glob_stat,
    output logic [15:0] link_data,
    output logic        link_frame
);

    localparam int SEG_WORDS = MAX_PAY_BYTES / 4 - 1;
    localparam int CW        = $clog2(FIFO_DEPTH + 1);

    qent_t          q_head;
    logic           q_pop, q_take;
    logic [CW-1:0]  q_pkts, q_used;
    logic           ctl_pend, ctl_start, seq_idle;

    lpf_queue #(.DEPTH(FIFO_DEPTH), .SEG_WORDS(SEG_WORDS)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (wr_valid),
        .in_ready (wr_ready),
        .in_word  (wr_word),
        .in_sop   (wr_sop),
        .in_eop   (wr_eop),
        .in_hdr   ('{dst: wr_dst, cmd: wr_cmd, src: wr_src}),
        .head     (q_head),
        .pop      (q_pop),
        .pkt_take (q_take),
        .pkts     (q_pkts),
        .used     (q_used)
    );

    lpf_ctl_sched #(.PERIOD(CTL_PERIOD)) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .port_stat (ctl_port_stat),
        .start     (ctl_start),
        .pend      (ctl_pend)
    );

    lpf_seq #(.SEG_WORDS(SEG_WORDS)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .head          (q_head),
        .pkts_nz       (q_pkts != '0),
        .ctl_pend      (ctl_pend),
        .ctl_dst       (ctl_dst),
        .ctl_cfg       (ctl_cfg),
        .ctl_port_stat (ctl_port_stat),
        .ctl_hub_stat  (ctl_hub_stat),
        .ctl_glob_stat (ctl_glob_stat),
        .pop           (q_pop),
        .pkt_take      (q_take),
        .ctl_start     (ctl_start),
        .idle          (seq_idle),
        .link_data     (link_data),
        .link_frame    (link_frame)
    );

endmodule

// File: rtl/link_pkt_fmt_chk.sv
// Property checker for the link packet formatter, bound to the top module.
module link_pkt_fmt_chk
    import lpf_pkg::*;
#(
    parameter int MAX_PAY_BYTES = 256,
    parameter int FIFO_DEPTH    = 128,
    localparam int CW      = $clog2(FIFO_DEPTH + 1),
    localparam int MAX_LEN = 5 + 2 * (MAX_PAY_BYTES / 4 - 1),
    localparam int FW      = $clog2(MAX_LEN + 2) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          link_frame,
    input logic [15:0]   link_data,
    input logic          wr_ready,
    input logic [CW-1:0] q_used,
    input logic [CW-1:0] q_pkts,
    input logic          ctl_pend,
    input logic          seq_idle
);

    logic [FW-1:0] flen;

    // Count cycles of the current frame
    always_ff @(posedge clk) begin
        if (!rst_n)          flen <= '0;
        else if (link_frame) flen <= flen + 1'b1;
        else                 flen <= '0;
    end

    assert_hdr_type_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_frame) |-> (link_data[15:12] == TYPE_DATA || link_data[15:12] == TYPE_CTRL));

    assert_frame_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_frame) |-> (flen[0] && flen >= FW'(5) && flen <= FW'(MAX_LEN)));

    assert_whole_pkt_queued_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(link_frame) && link_data[15:12] == TYPE_DATA) |-> $past(q_pkts) != '0);

    assert_ctl_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_pend && seq_idle) |=> (link_frame && link_data[15:12] == TYPE_CTRL));

    assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (q_used == CW'(FIFO_DEPTH)) |-> !wr_ready);

endmodule

bind link_pkt_fmt link_pkt_fmt_chk #(
    .MAX_PAY_BYTES (MAX_PAY_BYTES),
    .FIFO_DEPTH    (FIFO_DEPTH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .link_frame (link_frame),
    .link_data  (link_data),
    .wr_ready   (wr_ready),
    .q_used     (q_used),
    .q_pkts     (q_pkts),
    .ctl_pend   (ctl_pend),
    .seq_idle   (seq_idle)
);

// File: tb/link_pkt_fmt_tb.sv
module link_pkt_fmt_tb;

    localparam int CLK_PERIOD = 10;
    localparam int PERIOD     = 3000;
    localparam int DEPTH      = 64;
    localparam int SEG        = 63;
    localparam int MAXP       = 16;
    localparam int MAXL       = 136;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0, wr_sop = 1'b0, wr_eop = 1'b0;
    logic        wr_ready;
    logic [31:0] wr_word = '0;
    logic [3:0]  wr_dst = '0, wr_cmd = '0, wr_src = '0;
    logic [3:0]  ctl_dst = 4'h9;
    logic [7:0]  ctl_cfg = 8'h3C, ctl_port_stat = 8'h00, ctl_hub_stat = 8'h77;
    logic [15:0] ctl_glob_stat = 16'hBEEF;
    logic [15:0] link_data;
    logic        link_frame;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    bit ready_low_seen = 0;
    longint cyc = 0;

    logic [15:0] pk [MAXP][MAXL];
    int          pk_len [MAXP];
    longint      pk_t [MAXP];
    int          pk_n = 0;
    logic [15:0] cur [MAXL];
    int          cur_len = 0;
    longint      cur_t = 0;

    link_pkt_fmt #(.MAX_PAY_BYTES(256), .FIFO_DEPTH(DEPTH), .CTL_PERIOD(PERIOD)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_word(wr_word), .wr_sop(wr_sop), .wr_eop(wr_eop),
        .wr_dst(wr_dst), .wr_cmd(wr_cmd), .wr_src(wr_src),
        .ctl_dst(ctl_dst), .ctl_cfg(ctl_cfg), .ctl_port_stat(ctl_port_stat),
        .ctl_hub_stat(ctl_hub_stat), .ctl_glob_stat(ctl_glob_stat),
        .link_data(link_data), .link_frame(link_frame)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Link monitor: collects each framed packet
    always @(negedge clk) begin
        if (!rst_n) cur_len = 0;
        else if (link_frame) begin
            if (cur_len == 0) cur_t = cyc;
            if (cur_len < MAXL) cur[cur_len] = link_data;
            cur_len++;
        end else if (cur_len > 0) begin
            if (pk_n < MAXP) begin
                for (int i = 0; i < MAXL; i++) pk[pk_n][i] = cur[i];
                pk_len[pk_n] = cur_len;
                pk_t[pk_n]   = cur_t;
            end
            pk_n++;
            cur_len = 0;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int idx, input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int k = 0; k < n; k++) begin
            for (int b = 15; b >= 0; b--) begin
                logic fb;
                fb = c[31] ^ pk[idx][k][b];
                c = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
            end
        end
        return c;
    endfunction

    function automatic logic [31:0] dword(input logic [31:0] seed, input int i);
        return seed + 32'(i) * 32'h0001_0003;
    endfunction

    function automatic int nth(input logic [3:0] typ, input int n);
        int seen = 0;
        for (int i = 0; i < pk_n && i < MAXP; i++) begin
            if (pk[i][0][15:12] == typ) begin
                if (seen == n) return i;
                seen++;
            end
        end
        return -1;
    endfunction

    task automatic push(input logic [31:0] w, input bit sop, input bit eop);
        @(negedge clk);
        wr_valid = 1'b1; wr_word = w; wr_sop = sop; wr_eop = eop;
        while (!wr_ready) begin
            ready_low_seen = 1;
            @(negedge clk);
        end
    endtask

    task automatic release_bus();
        @(negedge clk);
        wr_valid = 1'b0; wr_sop = 1'b0; wr_eop = 1'b0;
    endtask

    task automatic send_write(input logic [3:0] d, input logic [3:0] c, input logic [3:0] s,
                              input logic [31:0] addr, input int n, input logic [31:0] seed);
        wr_dst = d; wr_cmd = c; wr_src = s;
        push(addr, 1'b1, n == 0);
        for (int i = 0; i < n; i++) push(dword(seed, i), 1'b0, i == n - 1);
        release_bus();
    endtask

    task automatic wait_idle();
        int q = 0;
        while (q < 30) begin
            @(negedge clk);
            q = link_frame ? 0 : q + 1;
        end
    endtask

    task automatic clear_log();
        wait_idle();
        pk_n = 0;
    endtask

    // Check one data packet: layout, address, data words and CRC
    task automatic check_data(input int idx, input logic [11:0] hdr, input logic [31:0] addr,
                              input logic [31:0] seed, input int first, input int n);
        int bad = 0;
        logic [31:0] c;
        if (idx < 0) begin
            check(0, "R2 data packet missing", 0, 1);
            return;
        end
        check(pk_len[idx] == 5 + 2 * n, "R4 frame length", pk_len[idx], 5 + 2 * n);
        check(pk[idx][0] == {4'h1, hdr}, "R1 header", pk[idx][0], {4'h1, hdr});
        check({pk[idx][1], pk[idx][2]} == addr, "R2 address", {pk[idx][1], pk[idx][2]}, addr);
        for (int i = 0; i < n; i++) begin
            if ({pk[idx][3 + 2 * i], pk[idx][4 + 2 * i]} != dword(seed, first + i)) bad++;
        end
        check(bad == 0, "R2 data halves", bad, 0);
        c = ref_crc(idx, 3 + 2 * n);
        check({pk[idx][3 + 2 * n], pk[idx][4 + 2 * n]} == c, "R3 crc",
              {pk[idx][3 + 2 * n], pk[idx][4 + 2 * n]}, c);
    endtask

    task automatic check_ctl(input int idx, input logic [7:0] pstat);
        logic [31:0] c;
        if (idx < 0) begin
            check(0, "R9 control packet missing", 0, 1);
            return;
        end
        check(pk_len[idx] == 5, "R9 control length", pk_len[idx], 5);
        check(pk[idx][0] == {4'hC, ctl_dst, ctl_cfg}, "R9 control word 0", pk[idx][0], {4'hC, ctl_dst, ctl_cfg});
        check(pk[idx][1] == {pstat, ctl_hub_stat}, "R9 control word 1", pk[idx][1], {pstat, ctl_hub_stat});
        check(pk[idx][2] == ctl_glob_stat, "R9 control word 2", pk[idx][2], ctl_glob_stat);
        c = ref_crc(idx, 3);
        check({pk[idx][3], pk[idx][4]} == c, "R3 control crc", {pk[idx][3], pk[idx][4]}, c);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(link_frame == 1'b0, "R4 frame low after reset", link_frame, 0);
        check(wr_ready == 1'b1, "R4 ready after reset", wr_ready, 1);
    endtask

    task automatic t_basic();
        clear_log();
        send_write(4'h5, 4'h3, 4'h2, 32'h1000_2000, 3, 32'hA0B0_C0D0);
        wait_idle();
        check_data(nth(4'h1, 0), 12'h532, 32'h1000_2000, 32'hA0B0_C0D0, 0, 3);
    endtask

    task automatic t_min();
        clear_log();
        send_write(4'h1, 4'h0, 4'hE, 32'hDEAD_0004, 0, 32'h0);
        wait_idle();
        check_data(nth(4'h1, 0), 12'h10E, 32'hDEAD_0004, 32'h0, 0, 0);
        check(nth(4'h1, 0) >= 0 && pk_len[nth(4'h1, 0)] == 5, "R6 address-only length",
              nth(4'h1, 0) >= 0 ? pk_len[nth(4'h1, 0)] : -1, 5);
    endtask

    task automatic t_two();
        clear_log();
        send_write(4'h2, 4'h4, 4'h6, 32'h0000_0100, 2, 32'h1111_0000);
        send_write(4'h3, 4'h5, 4'h7, 32'h0000_0200, 2, 32'h2222_0000);
        wait_idle();
        check(nth(4'h1, 1) >= 0 && nth(4'h1, 2) < 0, "R7 two writes give two packets",
              nth(4'h1, 1), 1);
        check_data(nth(4'h1, 0), 12'h246, 32'h0000_0100, 32'h1111_0000, 0, 2);
        check_data(nth(4'h1, 1), 12'h357, 32'h0000_0200, 32'h2222_0000, 0, 2);
    endtask

    task automatic t_split();
        clear_log();
        ready_low_seen = 0;
        send_write(4'h7, 4'h1, 4'h8, 32'h4000_0000, 100, 32'h5500_0000);
        wait_idle();
        check(ready_low_seen == 1, "R12 ready dropped on full queue", ready_low_seen, 1);
        check(nth(4'h1, 1) >= 0 && nth(4'h1, 2) < 0, "R5 long write split in two", nth(4'h1, 1), 1);
        check_data(nth(4'h1, 0), 12'h718, 32'h4000_0000, 32'h5500_0000, 0, SEG);
        check_data(nth(4'h1, 1), 12'h718, 32'h4000_0000 + 4 * SEG, 32'h5500_0000, SEG, 100 - SEG);
    endtask

    task automatic t_hold();
        clear_log();
        wr_dst = 4'hA; wr_cmd = 4'hB; wr_src = 4'hC;
        push(32'h0808_0000, 1'b1, 1'b0);
        push(dword(32'h7777_0000, 0), 1'b0, 1'b0);
        push(dword(32'h7777_0000, 1), 1'b0, 1'b0);
        release_bus();
        repeat (40) @(negedge clk);
        check(nth(4'h1, 0) < 0 && !(link_frame && link_data[15:12] == 4'h1),
              "R8 no data frame before closing word", nth(4'h1, 0), -1);
        push(dword(32'h7777_0000, 2), 1'b0, 1'b1);
        release_bus();
        wait_idle();
        check_data(nth(4'h1, 0), 12'hABC, 32'h0808_0000, 32'h7777_0000, 0, 3);
    endtask

    task automatic t_urgent();
        int i1;
        clear_log();
        send_write(4'h4, 4'h2, 4'h1, 32'h6000_0000, 40, 32'h3300_0000);
        send_write(4'h4, 4'h2, 4'h1, 32'h6000_1000, 1, 32'h4400_0000);
        repeat (10) @(negedge clk);
        ctl_port_stat = 8'h5A;
        wait_idle();
        i1 = nth(4'h1, 0);
        check_data(i1, 12'h421, 32'h6000_0000, 32'h3300_0000, 0, 40);
        check(i1 >= 0 && pk[i1 + 1][0][15:12] == 4'hC && pk[i1 + 1][1][15:8] == 8'h5A,
              "R10 control right after data packet", i1 >= 0 ? pk[i1 + 1][0] : 0, 16'hC000);
        if (i1 >= 0) check_ctl(i1 + 1, 8'h5A);
        check(nth(4'h1, 1) > i1 + 1, "R10 control ahead of queued data", nth(4'h1, 1), i1 + 2);
        check_data(nth(4'h1, 1), 12'h421, 32'h6000_1000, 32'h4400_0000, 0, 1);
    endtask

    task automatic t_idle_ctl();
        longint c0;
        int ic;
        clear_log();
        @(negedge clk);
        ctl_port_stat = 8'hA5;
        c0 = cyc;
        wait_idle();
        ic = nth(4'hC, 0);
        check(ic >= 0 && pk_t[ic] - c0 == 2, "R10 idle control latency",
              ic >= 0 ? 32'(pk_t[ic] - c0) : -1, 2);
        check_ctl(ic, 8'hA5);
    endtask

    task automatic t_periodic();
        int guard = 0;
        clear_log();
        while (nth(4'hC, 1) < 0 && guard < 3 * PERIOD) begin
            @(negedge clk);
            guard++;
        end
        check(nth(4'hC, 1) >= 0 && pk_t[nth(4'hC, 1)] - pk_t[nth(4'hC, 0)] == PERIOD,
              "R11 periodic control spacing",
              nth(4'hC, 1) >= 0 ? 32'(pk_t[nth(4'hC, 1)] - pk_t[nth(4'hC, 0)]) : -1, PERIOD);
        check_ctl(nth(4'hC, 1), 8'hA5);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_min();
        t_two();
        t_split();
        t_hold();
        t_urgent();
        t_idle_ctl();
        t_periodic();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule